// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by looking up one entry of a flat page table in memory. The page size is 4 KB. The virtual address splits into a 20-bit page number (bits 31:12) and a 12-bit byte offset (bits 11:0). A request carries the virtual address and an access kind: read, write or execute. The block adds the page number times four to a table base register, issues a single read on a request/response memory port, and examines the returned 32-bit entry.

Entry layout: bit 0 is valid, bit 1 allows reads, bit 2 allows writes, bit 3 allows execution, bits 6:4 hold present/referenced/dirty bookkeeping, and bits 31:12 hold the frame number. An invalid entry gives a segmentation fault. A valid entry whose permission bit for the requested kind is clear gives a protection fault. Otherwise the result is the frame number joined to the untouched offset. The validity check always takes precedence over the permission check.

The walker handles one request at a time. A caller presents `req_valid` while `busy` is low, waits for the one-cycle `done` pulse, and reads `fault` and `pa` in that cycle. Software loads the table base through a separate write port while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: During and right after reset, `busy`, `done` and `mem_rd_en` are low.
- R2: The entry read address equals the table base plus `req_va[31:12]` times 4, modulo 2^32.
- R3: Each accepted request issues exactly one memory read, with `mem_rd_en` high for the single cycle after acceptance.
- R4: An entry with bit 0 clear yields `fault` = 1 (segmentation) and `pa` = 0, whatever its permission bits are.
- R5: A valid entry yields `fault` = 2 (protection) and `pa` = 0 when the permission bit for the access is clear. Access code 0 (read) needs bit 1, code 1 (write) needs bit 2, code 2 (execute) needs bit 3. Code 3 is always refused.
- R6: A permitted access yields `fault` = 0 and `pa` = {entry[31:12], req_va[11:0]}.
- R7: Entry bits 6:4 (present, referenced, dirty) and bits 11:7 have no effect on `fault` or `pa`.
- R8: `busy` is high from the cycle after acceptance through the `done` cycle and low in the cycle after it. A request presented while busy is ignored and issues no read.
- R9: `done` is a one-cycle pulse in the cycle after `mem_rsp_valid` is seen while waiting for the entry.
- R10: `base_we` loads `base_wdata` into the table base only while idle. A write while busy is ignored, and later requests use the earlier base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when idle |
| req_va | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| busy | output | 1 | A translation is in progress |
| base_we | input | 1 | Table base write strobe |
| base_wdata | input | 32 | New table base |
| mem_rd_en | output | 1 | Entry read strobe |
| mem_rd_addr | output | 32 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 32 | Returned page table entry |
| done | output | 1 | One-cycle result strobe |
| fault | output | 2 | 0 none, 1 segmentation, 2 protection |
| pa | output | 32 | Physical address, zero on a fault |

## Verification
A corrupted latched offset or access kind appears in the very next `done` cycle as a wrong `pa` or a wrong fault code. The bench sweeps every combination of valid and permission bits against every access code, with differing metadata bits and offsets. A controller stuck outside idle shows up within one request as a missing `done`, an extra read, or `busy` held high. A base register that accepts writes while busy shows up in the entry address of the next request.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_PTE = 2'd1,
    ST_RESPOND  = 2'd2
  } walk_state_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_SEGV = 2'd1;
  localparam logic [1:0] FLT_PROT = 2'd2;

  localparam int ENT_VALID_BIT = 0;
  localparam int ENT_PERM_LSB  = 1;

endpackage

// File: rtl/pt_addr_split.sv
module pt_addr_split #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ADDR_W    = 32,
  parameter int ENT_LOG2  = 2
) (
  input  logic [VA_W-1:0]      va,
  input  logic [ADDR_W-1:0]    base,
  output logic [PAGE_BITS-1:0] offset,
  output logic [ADDR_W-1:0]    entry_addr
);
  localparam int VPN_W = VA_W - PAGE_BITS;

  logic [VPN_W-1:0] vpn;

  always_comb begin
    vpn        = va[VA_W-1:PAGE_BITS];
    offset     = va[PAGE_BITS-1:0];
    entry_addr = base + (ADDR_W'(vpn) << ENT_LOG2);
  end
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int PTE_W     = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [PTE_W-1:0]     pte,
  input  logic [1:0]           acc,
  input  logic [PAGE_BITS-1:0] offset,
  output logic [1:0]           fault,
  output logic [PTE_W-1:0]     pa
);
  localparam int FRAME_W = PTE_W - PAGE_BITS;

  logic [2:0]         perm;
  logic               allowed;
  logic [FRAME_W-1:0] frame;
  logic               unused_meta;

  assign unused_meta = ^pte[PAGE_BITS-1:ENT_PERM_LSB+3];

  always_comb begin
    perm  = pte[ENT_PERM_LSB +: 3];
    frame = pte[PTE_W-1:PAGE_BITS];
    case (acc)
      ACC_READ:  allowed = perm[0];
      ACC_WRITE: allowed = perm[1];
      ACC_EXEC:  allowed = perm[2];
      default:   allowed = 1'b0;
    endcase
    if (!pte[ENT_VALID_BIT]) begin
      fault = FLT_SEGV;
    end else if (!allowed) begin
      fault = FLT_PROT;
    end else begin
      fault = FLT_NONE;
    end
    if (fault == FLT_NONE) begin
      pa = {frame, offset};
    end else begin
      pa = '0;
    end
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        rsp_valid,
  output walk_state_e state,
  output logic        accept,
  output logic        capture,
  output logic        rd_issue
);
  walk_state_e state_d;

  always_comb begin
    state_d = state;
    accept  = 1'b0;
    capture = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_WAIT_PTE;
        end
      end
      ST_WAIT_PTE: begin
        if (rsp_valid) begin
          capture = 1'b1;
          state_d = ST_RESPOND;
        end
      end
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rd_issue <= 1'b0;
    end else begin
      state    <= state_d;
      rd_issue <= accept;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTE_W     = 32,
  parameter int ENT_LOG2  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_acc,
  output logic             busy,
  input  logic             base_we,
  input  logic [PTE_W-1:0] base_wdata,
  output logic             mem_rd_en,
  output logic [PTE_W-1:0] mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic [1:0]       fault,
  output logic [PTE_W-1:0] pa
);
  localparam int ADDR_W = PTE_W;

  walk_state_e          state;
  logic                 accept;
  logic                 capture;
  logic                 rd_issue;
  logic                 idle;

  logic [ADDR_W-1:0]    base_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [PAGE_BITS-1:0] offset_q;
  logic [1:0]           acc_q;
  logic [1:0]           fault_q;
  logic [ADDR_W-1:0]    pa_q;

  logic [PAGE_BITS-1:0] offset_d;
  logic [ADDR_W-1:0]    entry_addr_d;
  logic [1:0]           fault_d;
  logic [ADDR_W-1:0]    pa_d;

  logic base_en;
  logic req_en;
  logic res_en;

  pt_walk_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (mem_rsp_valid),
    .state     (state),
    .accept    (accept),
    .capture   (capture),
    .rd_issue  (rd_issue)
  );

  pt_addr_split #(
    .VA_W      (VA_W),
    .PAGE_BITS (PAGE_BITS),
    .ADDR_W    (ADDR_W),
    .ENT_LOG2  (ENT_LOG2)
  ) u_split (
    .va         (req_va),
    .base       (base_q),
    .offset     (offset_d),
    .entry_addr (entry_addr_d)
  );

  pt_entry_check #(
    .PTE_W     (PTE_W),
    .PAGE_BITS (PAGE_BITS)
  ) u_check (
    .pte    (mem_rsp_data),
    .acc    (acc_q),
    .offset (offset_q),
    .fault  (fault_d),
    .pa     (pa_d)
  );

  assign idle    = (state == ST_IDLE);
  assign base_en = base_we && idle;
  assign req_en  = accept;
  assign res_en  = capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      offset_q <= '0;
      acc_q    <= ACC_READ;
    end else if (req_en) begin
      addr_q   <= entry_addr_d;
      offset_q <= offset_d;
      acc_q    <= req_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= FLT_NONE;
      pa_q    <= '0;
    end else if (res_en) begin
      fault_q <= fault_d;
      pa_q    <= pa_d;
    end
  end

  assign busy        = !idle;
  assign mem_rd_en   = rd_issue;
  assign mem_rd_addr = addr_q;
  assign done        = (state == ST_RESPOND);
  assign fault       = fault_q;
  assign pa          = pa_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             mem_rd_en,
  input logic             mem_rsp_valid,
  input logic [1:0]       fault,
  input logic [PTE_W-1:0] pa,
  input logic [PTE_W-1:0] base_q
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_rsp_valid)); // R9
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R3
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy); // R8
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'd0) |-> (pa == '0)); // R4
  AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(base_q)); // R10
endmodule

bind pt_walker pt_walker_chk #(.PTE_W(PTE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .mem_rd_en     (mem_rd_en),
  .mem_rsp_valid (mem_rsp_valid),
  .fault         (fault),
  .pa            (pa),
  .base_q        (base_q)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_va;
  logic [1:0]  req_acc;
  logic        busy;
  logic        base_we;
  logic [31:0] base_wdata;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done;
  logic [1:0]  fault;
  logic [31:0] pa;

  int total = 0;
  int bad   = 0;
  int rd_cnt = 0;
  logic [31:0] exp_base;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_acc(req_acc), .busy(busy), .base_we(base_we), .base_wdata(base_wdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault), .pa(pa)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) if (rst_n && mem_rd_en) rd_cnt++;

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(input logic [31:0] pte, input logic [1:0] acc);
    if (!pte[0]) return 2'd1;
    if (acc == 2'd3) return 2'd2;
    if (!pte[1 + acc]) return 2'd2;
    return 2'd0;
  endfunction

  task automatic set_base(input logic [31:0] v);
    @(negedge clk);
    base_we = 1'b1; base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
    exp_base = v;
  endtask

  task automatic run_req(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] pte,
                         input int lat, input bit inject, input string tag);
    int start_cnt;
    logic [1:0]  ef;
    logic [31:0] ea, ep;
    ef = exp_fault(pte, acc);
    ep = (ef == 2'd0) ? {pte[31:12], va[11:0]} : 32'd0;
    ea = exp_base + {va[31:12], 2'b00};
    start_cnt = rd_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_rd_en === 1'b1, "R3 read strobe after accept", {31'd0, mem_rd_en}, 32'd1);
    chk(mem_rd_addr === ea, "R2 entry address", mem_rd_addr, ea);
    chk(busy === 1'b1, "R8 busy after accept", {31'd0, busy}, 32'd1);
    if (lat == 0) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
    end else begin
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        if (inject && k == 0) begin
          req_valid = 1'b1; req_va = ~va; req_acc = 2'd0;
          base_we = 1'b1; base_wdata = ~exp_base;
        end else begin
          req_valid = 1'b0; base_we = 1'b0;
        end
      end
      req_valid = 1'b0; base_we = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
    end
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
    chk(done === 1'b1, "R9 done after response", {31'd0, done}, 32'd1);
    chk(fault === ef, {tag, " fault code"}, {30'd0, fault}, {30'd0, ef});
    chk(pa === ep, {tag, " physical address"}, pa, ep);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", {31'd0, done}, 32'd0);
    chk(busy === 1'b0, "R8 idle after done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(rd_cnt - start_cnt == 1, inject ? "R8 request while busy ignored" : "R3 one read per request",
        rd_cnt - start_cnt, 32'd1);
  endtask

  function automatic string tag_of(input logic [31:0] pte, input logic [1:0] acc);
    logic [1:0] f;
    f = exp_fault(pte, acc);
    if (f == 2'd1) return "R4";
    if (f == 2'd2) return "R5";
    return "R6";
  endfunction

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_acc = '0;
    base_we = 1'b0; base_wdata = '0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    exp_base = 32'd0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_rd_en === 1'b0, "R1 reset outputs",
        {29'd0, busy, done, mem_rd_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_rd_en === 1'b0, "R1 after reset release",
        {29'd0, busy, done, mem_rd_en}, 32'd0);

    for (int b = 0; b < 2; b++) begin
      set_base(b == 0 ? 32'h0010_0000 : 32'h8000_4000);
      for (int a = 0; a < 4; a++) begin
        for (int ctl = 0; ctl < 16; ctl++) begin
          logic [31:0] va, pte;
          va  = (32'h0001_3000 * (ctl + 1 + 16 * a)) ^ (32'h0000_0ABC + ctl * 97);
          pte = {20'(32'h0F00D + ctl * 4099 + a * 77), 5'd0, 3'(ctl * 5 + a), ctl[3:0]};
          run_req(va, a[1:0], pte, (ctl + a) % 3, 1'b0, tag_of(pte, a[1:0]));
          pte[11:4] = ~pte[11:4];
          run_req(va, a[1:0], pte, 1, 1'b0, "R7");
        end
      end
    end

    set_base(32'hFFFF_F800);
    run_req(32'hFFFF_F123, 2'd0, 32'h1234_5003, 2, 1'b0, "R6");
    run_req(32'h0000_0FFF, 2'd2, 32'hABCD_E009, 0, 1'b0, "R6");
    run_req(32'h7654_3210, 2'd1, 32'h5555_500E, 1, 1'b0, "R4");

    run_req(32'h0004_5678, 2'd1, 32'h0009_9005, 3, 1'b1, "R8");
    chk(exp_base === 32'hFFFF_F800, "R10 bench base unchanged", exp_base, 32'hFFFF_F800);
    run_req(32'h0004_5678, 2'd1, 32'h0009_9005, 1, 1'b0, "R10");
    set_base(32'h0000_2000);
    run_req(32'h0000_1004, 2'd0, 32'h0000_1003, 1, 1'b0, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule